// File: doc/BRIEF.md
# ECG Envelope Extraction Pipeline

This block turns a stream of band-passed ECG samples into a smooth energy curve whose maxima line up with QRS complexes. Each accepted sample is squared. Local maxima of the squared stream are found from the sign of a three-point derivative, and the squared value at each maximum is held until the next one, giving a peak-hold envelope. That envelope is smoothed twice by recursive shift-and-add averagers: a slow one with a 1/64 weight, then a faster 1/8 low-pass stage. No multiplier is used beyond the squarer, and no divider or sample FIFO is needed.

Every register advances only on the sample strobe, which is nominally at 250 Hz. The output is the low-pass value with a valid flag. A one-cycle pulse marks each maximum of that value, and a downstream search stage uses these pulses as the boundaries of its search windows.

Top module: `ecg_envelope_pipe`

## Requirements
- R1: With `sample_stb` low, no state changes: `lp_out` and `lp_valid` hold, and `lp_peak` is low in the cycle after any non-strobe edge.
- R2: A sample x is squared as a signed value into a non-negative 33-bit result; x = -32768 yields 2^30 exactly.
- R3: At strobe n, the derivative is sq[n] - sq[n-2]. When the derivative of the previous strobe was positive and the current one is zero or negative, the envelope takes sq[n-1]. It holds its value at every other strobe.
- R4: At each strobe the average becomes avg + ((env - avg) >>> 6). The shift is arithmetic (floor), env is the envelope as it was before this strobe, and the result is clamped to [0, 2^39-1].
- R5: At each strobe `lp_out` becomes lp + ((avg - lp) >>> 3), with avg as it was before this strobe, clamped the same way.
- R6: `lp_peak` is high for exactly the cycle after a strobe edge at which the low-pass step (new minus old) is zero or negative while the previous step was positive. Only steps taken while `lp_valid` was already high count.
- R7: `lp_valid` goes high after the third strobe accepted since reset and then stays high.
- R8: Synchronous active-high `rst` clears every register: `lp_out` = 0, `lp_valid` = 0, `lp_peak` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_stb | input | 1 | One-cycle strobe: accept `sample_in` |
| sample_in | input | 16 | Signed two's complement filtered ECG sample |
| lp_out | output | 40 | Low-pass smoothed envelope, non-negative |
| lp_valid | output | 1 | High once the derivative history is full |
| lp_peak | output | 1 | One-cycle pulse at a maximum of `lp_out` |

## Verification
The bench builds the block with its defaults: 16-bit samples, a 33-bit square, a 40-bit accumulator, an average shift of 6 and a low-pass shift of 3. These make the full-scale negative sample reachable, so the square reaches 2^30 and the envelope lands in the top of the range. The bench drives synthetic beats both back to back and with strobes spaced several cycles apart, so the hold behaviour between strobes is exercised. Alternating beat and ripple energy makes the envelope fall as well as rise, and this produces low-pass maxima and their pulses.

// File: rtl/ecg_env_pkg.sv
package ecg_env_pkg;
    typedef logic [1:0] fill_t;
    localparam fill_t FILL_DERIV = 2'd2;
    localparam fill_t FILL_FULL  = 2'd3;
endpackage

// File: rtl/ecg_sq_peakhold.sv
module ecg_sq_peakhold
    import ecg_env_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int SQ_W     = 2 * SAMPLE_W + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                stb_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic [SQ_W-1:0]     env_o,
    output logic                full_o
);
    localparam int EXT_W = SQ_W - SAMPLE_W;

    typedef struct packed {
        logic [SQ_W-1:0] sq_now;
        logic [SQ_W-1:0] sq_old;
        logic [SQ_W-1:0] env;
        logic            slope_up;
        fill_t           fill;
    } ph_state_t;

    ph_state_t st_q, st_d;
    logic signed [SQ_W-1:0] x_ext;
    logic signed [SQ_W-1:0] sq_w;
    logic signed [SQ_W-1:0] deriv_w;

    always_comb begin
        x_ext   = $signed({{EXT_W{sample_i[SAMPLE_W-1]}}, sample_i});
        sq_w    = x_ext * x_ext;
        deriv_w = sq_w - $signed(st_q.sq_old);
        st_d    = st_q;
        if (stb_i) begin
            st_d.sq_now = sq_w;
            st_d.sq_old = st_q.sq_now;
            if (st_q.fill >= FILL_DERIV) begin
                st_d.slope_up = (deriv_w > 0);
            end
            if (st_q.fill == FILL_FULL && st_q.slope_up && deriv_w <= 0) begin
                st_d.env = st_q.sq_now;
            end
            if (st_q.fill != FILL_FULL) begin
                st_d.fill = st_q.fill + 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign env_o  = st_q.env;
    assign full_o = (st_q.fill == FILL_FULL);

    assert_env_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !stb_i |=> $stable(env_o));
    assert_square_positive_R2: assert property (@(posedge clk) disable iff (rst)
        stb_i |=> !st_q.sq_now[SQ_W-1]);
    assert_full_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        full_o |=> full_o);
endmodule

// File: rtl/ecg_shift_smoother.sv
module ecg_shift_smoother #(
    parameter int IN_W  = 33,
    parameter int W     = 40,
    parameter int SHIFT = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stb_i,
    input  logic [IN_W-1:0] x_i,
    output logic [W-1:0]  y_o,
    output logic [W-1:0]  y_next_o
);
    localparam int SUM_W = W + 2;
    localparam logic signed [SUM_W-1:0] TOP_V = (SUM_W'(1) <<< (W - 1)) - SUM_W'(1);

    typedef struct packed {
        logic [W-1:0] y;
    } sm_state_t;

    sm_state_t st_q, st_d;
    logic signed [W:0]       x_ext;
    logic signed [W:0]       y_ext;
    logic signed [W:0]       delta_w;
    logic signed [W:0]       step_w;
    logic signed [SUM_W-1:0] sum_w;
    logic [W-1:0]            sat_w;

    always_comb begin
        x_ext   = $signed({{(W + 1 - IN_W){1'b0}}, x_i});
        y_ext   = $signed({1'b0, st_q.y});
        delta_w = x_ext - y_ext;
        step_w  = delta_w >>> SHIFT;
        sum_w   = $signed({y_ext[W], y_ext}) + $signed({step_w[W], step_w});
        if (sum_w < 0) begin
            sat_w = '0;
        end else if (sum_w > TOP_V) begin
            sat_w = TOP_V[W-1:0];
        end else begin
            sat_w = sum_w[W-1:0];
        end
        st_d = st_q;
        if (stb_i) begin
            st_d.y = sat_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign y_o      = st_q.y;
    assign y_next_o = sat_w;

    assert_hold_no_strobe_R1: assert property (@(posedge clk) disable iff (rst)
        !stb_i |=> $stable(y_o));
    assert_moves_toward_input_R4: assert property (@(posedge clk) disable iff (rst)
        (stb_i && ({{(W - IN_W){1'b0}}, x_i} >= y_o)) |=> (y_o >= $past(y_o)));
    assert_stays_non_negative_R4: assert property (@(posedge clk) disable iff (rst)
        stb_i |=> !y_o[W-1]);
endmodule

// File: rtl/ecg_peak_marker.sv
module ecg_peak_marker #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stb_i,
    input  logic         full_i,
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] nxt_i,
    output logic         peak_o
);
    typedef struct packed {
        logic rising;
        logic peak;
    } mk_state_t;

    mk_state_t st_q, st_d;
    logic signed [W:0] diff_w;

    always_comb begin
        diff_w    = $signed({1'b0, nxt_i}) - $signed({1'b0, cur_i});
        st_d      = st_q;
        st_d.peak = stb_i && full_i && st_q.rising && (diff_w <= 0);
        if (stb_i && full_i) begin
            st_d.rising = (diff_w > 0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign peak_o = st_q.peak;

    assert_peak_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
        peak_o |-> (cur_i <= $past(cur_i)));
    assert_peak_needs_strobe_R1: assert property (@(posedge clk) disable iff (rst)
        !stb_i |=> !peak_o);
endmodule

// File: rtl/ecg_envelope_pipe.sv
module ecg_envelope_pipe #(
    parameter int SAMPLE_W   = 16,
    parameter int ACC_W      = 40,
    parameter int AVG_SHIFT  = 6,
    parameter int LP_SHIFT   = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sample_stb,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic [ACC_W-1:0]    lp_out,
    output logic                lp_valid,
    output logic                lp_peak
);
    localparam int SQ_W = 2 * SAMPLE_W + 1;

    logic [SQ_W-1:0]  env_w;
    logic             full_w;
    logic [ACC_W-1:0] avg_w;
    logic [ACC_W-1:0] avg_next_w;
    logic [ACC_W-1:0] lp_w;
    logic [ACC_W-1:0] lp_next_w;

    ecg_sq_peakhold #(.SAMPLE_W(SAMPLE_W), .SQ_W(SQ_W)) u_peakhold (
        .clk(clk), .rst(rst), .stb_i(sample_stb), .sample_i(sample_in),
        .env_o(env_w), .full_o(full_w)
    );

    ecg_shift_smoother #(.IN_W(SQ_W), .W(ACC_W), .SHIFT(AVG_SHIFT)) u_average (
        .clk(clk), .rst(rst), .stb_i(sample_stb), .x_i(env_w),
        .y_o(avg_w), .y_next_o(avg_next_w)
    );

    ecg_shift_smoother #(.IN_W(ACC_W - 1), .W(ACC_W), .SHIFT(LP_SHIFT)) u_lowpass (
        .clk(clk), .rst(rst), .stb_i(sample_stb), .x_i(avg_w[ACC_W-2:0]),
        .y_o(lp_w), .y_next_o(lp_next_w)
    );

    ecg_peak_marker #(.W(ACC_W)) u_marker (
        .clk(clk), .rst(rst), .stb_i(sample_stb), .full_i(full_w),
        .cur_i(lp_w), .nxt_i(lp_next_w), .peak_o(lp_peak)
    );

    assign lp_out   = lp_w;
    assign lp_valid = full_w;

    assert_avg_commit_R4: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> (avg_w == $past(avg_next_w)));
    assert_peak_only_valid_R6: assert property (@(posedge clk) disable iff (rst)
        lp_peak |-> lp_valid);
endmodule

// File: tb/ecg_envelope_pipe_bench.sv
module ecg_envelope_pipe_bench;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               sample_stb = 1'b0;
    logic signed [15:0] sample_in = '0;
    logic [39:0]        lp_out;
    logic               lp_valid;
    logic               lp_peak;

    always #2 clk = ~clk;

    ecg_envelope_pipe u_ecg_envelope_pipe (
        .clk(clk), .rst(rst), .sample_stb(sample_stb), .sample_in(sample_in),
        .lp_out(lp_out), .lp_valid(lp_valid), .lp_peak(lp_peak)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    n_peaks = 0;
    string phase = "R8";

    longint m_s0, m_s1, m_env, m_avg, m_lp;
    bit     m_up, m_rise, m_pk;
    int     m_fill;
    localparam longint TOPV = (64'sd1 <<< 39) - 1;

    function automatic longint sat(input longint v);
        if (v < 0) return 0;
        if (v > TOPV) return TOPV;
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        m_s0 = 0; m_s1 = 0; m_env = 0; m_avg = 0; m_lp = 0;
        m_up = 0; m_rise = 0; m_pk = 0; m_fill = 0;
    endtask

    // Behavioural model of one clock edge (R2..R7 arithmetic, R1 hold, R8 clear)
    task automatic model_edge(input bit r, input bit s, input longint x);
        longint sq, d, nenv, navg, nlp, diff;
        if (r) begin model_clear(); return; end
        if (!s) begin m_pk = 0; return; end
        sq   = x * x;
        d    = sq - m_s1;
        nenv = (m_fill == 3 && m_up && d <= 0) ? m_s0 : m_env;
        if (m_fill >= 2) m_up = (d > 0);
        navg = sat(m_avg + ((m_env - m_avg) >>> 6));
        nlp  = sat(m_lp + ((m_avg - m_lp) >>> 3));
        diff = nlp - m_lp;
        m_pk = (m_fill == 3) && m_rise && (diff <= 0);
        if (m_fill == 3) m_rise = (diff > 0);
        m_s1 = m_s0; m_s0 = sq; m_env = nenv; m_avg = navg; m_lp = nlp;
        if (m_fill < 3) m_fill++;
    endtask

    task automatic compare_all();
        check(longint'(lp_out) == m_lp, {phase, " R5 lp_out"}, longint'(lp_out), m_lp);
        check(lp_valid == (m_fill == 3), {phase, " R7 lp_valid"}, lp_valid, (m_fill == 3));
        check(lp_peak == m_pk, {phase, " R6 lp_peak"}, lp_peak, m_pk);
        if (m_pk) n_peaks++;
    endtask

    task automatic step(input bit r, input bit s, input int x);
        @(negedge clk);
        compare_all();
        rst = r; sample_stb = s; sample_in = 16'(x);
        model_edge(r, s, longint'(x));
    endtask

    function automatic int beat(input int p, input int amp);
        if (p < 8)  return (p < 4) ? amp * (p + 1) / 4 : amp * (8 - p) / 4;
        if (p < 10) return -amp / 4;
        if (p >= 30 && p < 50) return (p < 40) ? amp * (p - 29) / 30 : amp * (50 - p) / 30;
        return ((p % 8) < 2) ? 300 : 0;
    endfunction

    bit done = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (2) @(negedge clk);
        rst = 1; model_edge(1, 0, 0);
        for (int i = 0; i < 3; i++) step(1, 0, 0);
        step(0, 0, 0);
        // R8: reset state
        check(lp_out == 0 && !lp_valid && !lp_peak, "R8 reset outputs", longint'(lp_out), 0);
        // R7: valid after third strobe only
        phase = "R7";
        for (int i = 0; i < 3; i++) begin
            step(0, 1, 1000 * (i + 1));
            @(posedge clk); #1;
            check(lp_valid == (i == 2), "R7 valid fill", lp_valid, (i == 2));
        end
        // R3/R4/R5/R6: back-to-back beats
        phase = "R3";
        for (int b = 0; b < 8; b++)
            for (int p = 0; p < 100; p++) step(0, 1, beat(p, 20000));
        // R1: strobes spaced three cycles apart
        phase = "R1";
        for (int b = 0; b < 6; b++)
            for (int p = 0; p < 100; p++) begin
                step(0, 1, beat(p, 12000));
                step(0, 0, 7777);
                step(0, 0, -5);
            end
        // R1: hold check at the ports after a long gap
        begin
            longint held;
            held = longint'(lp_out);
            for (int i = 0; i < 5; i++) step(0, 0, 31000);
            check(longint'(lp_out) == held && !lp_peak, "R1 hold during gap", longint'(lp_out), held);
        end
        // R2: inverted full-scale beats including -32768
        phase = "R2";
        for (int b = 0; b < 4; b++)
            for (int p = 0; p < 100; p++) step(0, 1, (p == 3) ? -32768 : -beat(p, 32767));
        // random noise
        phase = "R4";
        for (int i = 0; i < 500; i++) step(0, ($urandom % 4) != 0, int'($urandom % 65536) - 32768);
        // R8: mid-run reset
        phase = "R8";
        step(1, 1, 12345);
        step(0, 0, 0);
        check(lp_out == 0 && !lp_valid && !lp_peak, "R8 mid-run reset", longint'(lp_out), 0);
        for (int p = 0; p < 100; p++) step(0, 1, beat(p, 15000));
        step(0, 0, 0);
        // R6: maxima must have been marked
        check(n_peaks > 0, "R6 peaks observed", n_peaks, 1);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule